// File: doc/BRIEF.md
# Shadow Stack Pointer CSR Access Gate

This block guards the register that holds the shadow stack pointer. On each request it looks at the current privilege level, the virtualization bit and three shadow-stack enable bits. The enable bits come from the machine, supervisor and hypervisor environment-configuration registers. From these it chooses one of three outcomes: the access is allowed, it raises an illegal-instruction fault, or it raises a virtual-instruction fault. The block also holds the pointer register itself, which is XLEN bits wide.

The fault type comes from an ordered chain of checks. The machine-level enable is tested first, for every mode below machine mode. After that the supervisor-level enable is tested for plain user mode. Last come the guest modes, where a missing hypervisor-level or supervisor-level enable raises a virtual-instruction fault instead of an illegal-instruction fault. Machine mode is never blocked.

The response is registered. A request presented in one cycle gets its verdict and read data in the next cycle. An allowed write replaces the pointer on the same clock edge. Read data always shows the pointer value from before that edge. The parameter `HAS_HYP` selects whether the virtualization bit is honoured (1) or treated as zero (0).

Top module: `ssp_csr_gate`

## Requirements
- R1: Encodings: privilege 2'b00 user, 2'b01 supervisor, 2'b11 machine, 2'b10 reserved. Verdict 2'b00 allow, 2'b01 illegal-instruction, 2'b10 virtual-instruction. After reset the response is invalid, the verdict reads allow, read data is zero and the pointer holds zero.
- R2: A machine-mode access is allowed for every combination of enable bits and virtualization bit.
- R3: In any mode below machine, with the machine-level enable clear, the verdict is illegal-instruction. This applies to guest modes too.
- R4: If R3 does not apply, user mode with the virtualization bit clear and the supervisor-level enable clear gives illegal-instruction.
- R5: If no earlier rule applies, supervisor mode with the virtualization bit set (guest supervisor) and the hypervisor-level enable clear gives virtual-instruction.
- R6: If no earlier rule applies, user mode with the virtualization bit set (guest user) gives virtual-instruction when either the hypervisor-level or the supervisor-level enable is clear.
- R7: Any access not caught by R3 to R6 or R12 is allowed.
- R8: The response valid is high exactly in the cycle after a request cycle and low after a cycle without a request. The verdict and read data are presented in that same cycle.
- R9: An allowed write updates the pointer at the clock edge that samples it. Read data of an allowed access returns the pointer value from before that edge.
- R10: A faulting access, read or write, leaves the pointer unchanged, and its read data is zero.
- R11: With `HAS_HYP` = 0 the virtualization bit has no effect. A supervisor access with the bit set is then judged as plain supervisor.
- R12: The reserved privilege encoding 2'b10 always gives illegal-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization bit |
| menv_sse_i | input | 1 | Machine-level shadow stack enable |
| senv_sse_i | input | 1 | Supervisor-level shadow stack enable |
| henv_sse_i | input | 1 | Hypervisor-level shadow stack enable |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | Request is a write |
| req_wdata_i | input | XLEN | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_verdict_o | output | 2 | Access verdict |
| rsp_rdata_o | output | XLEN | Pointer value before the access (zero on fault) |

## Verification
On every cycle the assertions check four things. Each request is followed by a response, and no response appears without one. Machine-mode and reserved-mode requests get their fixed verdicts. A guest supervisor access without the hypervisor enable (and with the machine enable set) reports a virtual-instruction fault. A rejected request never moves the pointer, and its returned data is zero.

Some behaviour only the bench's scenarios can show. The full priority chain is checked across every mode and enable combination against an independent model. The old-value-before-write ordering is visible only through chained accesses. The variant that ignores the virtualization bit is checked against the default one.

// File: rtl/ssp_gate_pkg.sv
package ssp_gate_pkg;

   typedef enum logic [1:0] {
      PRV_USER     = 2'b00,
      PRV_SUPER    = 2'b01,
      PRV_RESERVED = 2'b10,
      PRV_MACHINE  = 2'b11
   } ssp_priv_e;

   typedef enum logic [1:0] {
      VERD_ALLOW   = 2'b00,
      VERD_ILLEGAL = 2'b01,
      VERD_VIRTUAL = 2'b10
   } ssp_verdict_e;

endpackage

// File: rtl/ssp_access_rules.sv
module ssp_access_rules
   import ssp_gate_pkg::*;
#(
   parameter bit HAS_HYP = 1'b1
) (
   input  logic [1:0]   priv,
   input  logic         virt,
   input  logic         m_en,
   input  logic         s_en,
   input  logic         h_en,
   output ssp_verdict_e verdict
);

   logic virt_eff;

   generate
      if (HAS_HYP) begin : g_hyp
         assign virt_eff = virt;
      end else begin : g_nohyp
         logic unused_virt;
         assign unused_virt = virt;
         assign virt_eff    = 1'b0;
      end
   endgenerate

   logic in_m, in_res, in_u, in_s, below_m;
   assign in_m    = (priv == PRV_MACHINE);
   assign in_res  = (priv == PRV_RESERVED);
   assign in_u    = (priv == PRV_USER);
   assign in_s    = (priv == PRV_SUPER);
   assign below_m = in_u | in_s;

   // Ordered chain: first matching rule wins.
   always_comb begin
      verdict = VERD_ALLOW;
      if (in_res)
         verdict = VERD_ILLEGAL;
      else if (below_m && !m_en)
         verdict = VERD_ILLEGAL;
      else if (in_u && !virt_eff && !s_en)
         verdict = VERD_ILLEGAL;
      else if (in_s && virt_eff && !h_en)
         verdict = VERD_VIRTUAL;
      else if (in_u && virt_eff && (!h_en || !s_en))
         verdict = VERD_VIRTUAL;
      else if (in_m)
         verdict = VERD_ALLOW;
   end

endmodule

// File: rtl/ssp_ptr_reg.sv
module ssp_ptr_reg #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata;
   end

endmodule

// File: rtl/ssp_csr_gate.sv
module ssp_csr_gate
   import ssp_gate_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      priv_i,
   input  logic            virt_i,
   input  logic            menv_sse_i,
   input  logic            senv_sse_i,
   input  logic            henv_sse_i,
   input  logic            req_valid_i,
   input  logic            req_write_i,
   input  logic [XLEN-1:0] req_wdata_i,
   output logic            rsp_valid_o,
   output logic [1:0]      rsp_verdict_o,
   output logic [XLEN-1:0] rsp_rdata_o
);

   localparam logic [XLEN-1:0] ZERO_WORD = '0;

   initial begin
      assert (XLEN == 32 || XLEN == 64)
         else $error("ssp_csr_gate: XLEN must be 32 or 64");
   end

   ssp_verdict_e    verdict_c;
   logic            allow_c;
   logic            wr_en;
   logic [XLEN-1:0] ptr_q;

   ssp_access_rules #(.HAS_HYP(HAS_HYP)) u_rules (
      .priv    (priv_i),
      .virt    (virt_i),
      .m_en    (menv_sse_i),
      .s_en    (senv_sse_i),
      .h_en    (henv_sse_i),
      .verdict (verdict_c)
   );

   assign allow_c = (verdict_c == VERD_ALLOW);
   assign wr_en   = req_valid_i & req_write_i & allow_c;

   ssp_ptr_reg #(.XLEN(XLEN)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (req_wdata_i),
      .q     (ptr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o   <= 1'b0;
         rsp_verdict_o <= VERD_ALLOW;
         rsp_rdata_o   <= ZERO_WORD;
      end else begin
         rsp_valid_o <= req_valid_i;
         if (req_valid_i) begin
            rsp_verdict_o <= verdict_c;
            rsp_rdata_o   <= allow_c ? ptr_q : ZERO_WORD;
         end
      end
   end

   // Assertions
   assert_rsp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);
   assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !rsp_valid_o);
   assert_machine_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && priv_i == PRV_MACHINE) |=> (rsp_verdict_o == VERD_ALLOW));
   assert_reserved_illegal_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && priv_i == PRV_RESERVED) |=> (rsp_verdict_o == VERD_ILLEGAL));
   assert_no_menv_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && (priv_i == PRV_USER || priv_i == PRV_SUPER) && !menv_sse_i)
      |=> (rsp_verdict_o == VERD_ILLEGAL));
   assert_fault_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !allow_c) |=> $stable(ptr_q));
   assert_fault_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_verdict_o != VERD_ALLOW) |-> (rsp_rdata_o == ZERO_WORD));

   generate
      if (HAS_HYP) begin : g_hyp_chk
         assert_guest_super_virtual_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i && priv_i == PRV_SUPER && virt_i && menv_sse_i && !henv_sse_i)
            |=> (rsp_verdict_o == VERD_VIRTUAL));
      end
   endgenerate

endmodule

// File: tb/tb_ssp_csr_gate.sv
module tb_ssp_csr_gate;
   import ssp_gate_pkg::*;

   localparam int   XLEN   = 64;
   localparam time  CLK_PERIOD = 10ns;
   localparam logic [1:0] V_OK  = 2'b00;
   localparam logic [1:0] V_ILL = 2'b01;
   localparam logic [1:0] V_VIR = 2'b10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      priv = 2'b11;
   logic            virt = 1'b0, m_en = 1'b0, s_en = 1'b0, h_en = 1'b0;
   logic            req_valid = 1'b0, req_write = 1'b0;
   logic [XLEN-1:0] wdata = '0;
   logic            rsp_valid, rsp_valid_nh;
   logic [1:0]      rsp_verdict, rsp_verdict_nh;
   logic [XLEN-1:0] rsp_rdata, rsp_rdata_nh;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [XLEN-1:0] model_ptr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssp_csr_gate #(.XLEN(XLEN), .HAS_HYP(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt),
      .menv_sse_i(m_en), .senv_sse_i(s_en), .henv_sse_i(h_en),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_wdata_i(wdata),
      .rsp_valid_o(rsp_valid), .rsp_verdict_o(rsp_verdict), .rsp_rdata_o(rsp_rdata));

   ssp_csr_gate #(.XLEN(XLEN), .HAS_HYP(1'b0)) dut_nohyp (
      .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt),
      .menv_sse_i(m_en), .senv_sse_i(s_en), .henv_sse_i(h_en),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_wdata_i(wdata),
      .rsp_valid_o(rsp_valid_nh), .rsp_verdict_o(rsp_verdict_nh), .rsp_rdata_o(rsp_rdata_nh));

   // Reference: mode first, then the enables it needs.
   function automatic logic [1:0] ref_verdict(logic [1:0] p, logic v, logic m, logic s, logic h);
      case (p)
         2'b11: return V_OK;
         2'b10: return V_ILL;
         2'b01: begin
            if (!m)          return V_ILL;
            if (v && !h)     return V_VIR;
            return V_OK;
         end
         default: begin
            if (!m)          return V_ILL;
            if (!v)          return s ? V_OK : V_ILL;
            if (!(h && s))   return V_VIR;
            return V_OK;
         end
      endcase
   endfunction

   task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One request cycle; the response is sampled at the following falling edge.
   task automatic access(string req, logic [1:0] p, logic v, logic m, logic s, logic h,
                         logic wr, logic [XLEN-1:0] d);
      logic [1:0] ev;
      logic [XLEN-1:0] ed;
      priv = p; virt = v; m_en = m; s_en = s; h_en = h;
      req_write = wr; wdata = d; req_valid = 1'b1;
      ev = ref_verdict(p, v, m, s, h);
      ed = (ev == V_OK) ? model_ptr : '0;
      if (ev == V_OK && wr) model_ptr = d;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " R8 valid"}, XLEN'(rsp_valid), XLEN'(1'b1));
      check({req, " verdict"}, XLEN'(rsp_verdict), XLEN'(ev));
      check({req, " R9/R10 rdata"}, rsp_rdata, ed);
   endtask

   typedef struct packed {
      logic [1:0] p;
      logic       v, m, s, h;
      logic [1:0] exp;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, V_OK },  // R2
      '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, V_OK },  // R2
      '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, V_ILL},  // R3
      '{2'b00, 1'b1, 1'b0, 1'b1, 1'b1, V_ILL},  // R3
      '{2'b00, 1'b0, 1'b1, 1'b0, 1'b1, V_ILL},  // R4
      '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, V_VIR},  // R5
      '{2'b00, 1'b1, 1'b1, 1'b0, 1'b1, V_VIR},  // R6
      '{2'b00, 1'b1, 1'b1, 1'b1, 1'b0, V_VIR},  // R6
      '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, V_OK },  // R7
      '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0, V_OK },  // R7
      '{2'b00, 1'b1, 1'b1, 1'b1, 1'b1, V_OK },  // R7
      '{2'b10, 1'b0, 1'b1, 1'b1, 1'b1, V_ILL}   // R12
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset valid",   XLEN'(rsp_valid),   '0);
      check("R1 reset verdict", XLEN'(rsp_verdict), '0);
      check("R1 reset rdata",   rsp_rdata,          '0);
      rst_n = 1'b1;
      @(negedge clk);
      access("R1 pointer reset", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // Table of vectors: verdict from the table, pointer tracked by the model
      for (int i = 0; i < 12; i++) begin
         check("R2-R7/R12 table vs model", XLEN'(ref_verdict(VECS[i].p, VECS[i].v,
               VECS[i].m, VECS[i].s, VECS[i].h)), XLEN'(VECS[i].exp));
         access("R2/R3/R4/R5/R6/R7/R12 table", VECS[i].p, VECS[i].v, VECS[i].m,
                VECS[i].s, VECS[i].h, 1'b1, {32'hA5A5_0000 + 32'(i), 32'(i)});
      end

      // Exhaustive sweep of mode x virt x enables, alternating writes and reads
      for (int i = 0; i < 64; i++) begin
         access("R3/R4/R5/R6/R7 sweep", i[5:4], i[3], i[2], i[1], i[0], i[0] ^ i[3],
                {32'h5A00_0000 + 32'(i), ~32'(i)});
      end

      // R9: back-to-back allowed writes return the previous value
      access("R9 write A", 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1111_2222_3333_4444);
      access("R9 write B", 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 64'hFFFF_0000_FFFF_0000);
      access("R9 read",    2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R10: faulting writes do not disturb the pointer
      access("R10 ill write", 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
      access("R10 vir write", 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 64'hBAD0_BAD0_BAD0_BAD0);
      access("R10 readback",  2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

      // R8: idle cycle gives no response
      @(negedge clk);
      check("R8 idle valid", XLEN'(rsp_valid), '0);

      // R11: variant without virtualization ignores the bit
      access("R11 guest super", 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      check("R11 nohyp verdict super", XLEN'(rsp_verdict_nh), XLEN'(V_OK));
      access("R11 guest user", 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      check("R11 nohyp verdict user", XLEN'(rsp_verdict_nh), XLEN'(V_OK));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule